// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Spare-Bit Generator

This block produces the single bit that a 2.048 Mbit/s, 32-timeslot framed transmitter places in the first bit position of timeslot zero. It watches the outgoing serial PCM stream, the timeslot-zero marker and the sync-frame marker. It tracks its place in a 16-frame multiframe made of two 8-frame halves (submultiframes). When the CRC mode is on, it fills that bit position from three sources: a 4-bit check word computed over the previous half, a fixed 6-bit alignment pattern, and two user bits. When the CRC mode is off, it forwards one of two user bits, chosen by frame type.

The spare bit is a combinational output. The framing-word builder downstream samples it on the same rising clock edge that samples the first timeslot-zero bit, which is the first clock with the timeslot-zero marker high. The serial input is taken on every clock and the output is needed on every frame. The line rate cannot stall, so the stream has no valid/ready pair and no back-pressure: every clock carries a bit, and a consumer that is late loses that frame's bit.

Top module: `e1mf_spare_gen`

## Requirements
- R1: With `crc_en` low, `spare_bit` equals `usr_sync` while `sync_mark` is high and `usr_nonsync` while it is low. `sync_mark` already shows the type of the upcoming frame before that frame's timeslot zero.
- R2: A frame counter runs from 0 to 15 and wraps. It advances once at the end of each high pulse of `ts0_mark`, which is 8 clocks long. The first frame started after reset is frame 0, and even-numbered frames are sync frames.
- R3: With `crc_en` high, the even frames 0, 2, 4 and 6 carry check bits C1, C2, C3 and C4, and frames 8, 10, 12 and 14 carry them again. C1 is the x^3 coefficient of the check word and C4 the x^0 coefficient.
- R4: With `crc_en` high, the odd frames 1, 3, 5, 7, 9 and 11 carry 0, 0, 1, 0, 1, 1 in that order.
- R5: With `crc_en` high, frame 13 carries `usr_sync` and frame 15 carries `usr_nonsync`.
- R6: The check word of a half is the remainder of (the half's 2048 bits times x^4) divided by x^4+x+1. The bits are taken first-in as most significant, and the first bit of each even frame counts as 0. The half opens with the first timeslot-zero bit of frame 0 or frame 8. Its check word is sent in the even frames of the next half.
- R7: `spare_bit` for a frame is valid in the clock cycle just before the first clock with `ts0_mark` high.
- R8: A synchronous reset clears the frame counter and both check registers. Bits that arrive between reset and the next frame start are excluded, so the first half after reset sends the check word 0000.
- R9: The counter and check computation keep running while `crc_en` is low. After `crc_en` returns high, the check bits reflect the data sent during the time it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ts0_mark | input | 1 | High for the 8 bit clocks of timeslot zero |
| sync_mark | input | 1 | High when the current or upcoming frame is a sync frame |
| pcm_in | input | 1 | Outgoing serial PCM bit, one per clock |
| usr_sync | input | 1 | User bit for sync frames (or frame 13 in CRC mode) |
| usr_nonsync | input | 1 | User bit for non-sync frames (or frame 15 in CRC mode) |
| crc_en | input | 1 | High selects the CRC multiframe mode |
| spare_bit | output | 1 | Bit for position 1 of the upcoming timeslot zero |

## Verification
Properties are checked on every clock for the following: the frame counter steps by one only at the falling edge of the timeslot-zero marker and holds otherwise, the held check word changes only at a half's first bit, the fixed alignment-pattern frames show their constant values, and reset leaves the counter cleared. Only the bench scenarios can show that the check bits equal an independently computed remainder over random data and over all-ones data. The same applies to the disabled-mode pass-through, the user-bit slots, the exclusion of bits after a mid-frame reset, and correct check words after CRC mode is switched off and back on.

// File: rtl/e1mf_pkg.sv
package e1mf_pkg;
  localparam int MF_FRAMES  = 16;
  localparam int SMF_FRAMES = MF_FRAMES / 2;
  localparam int FN_W       = $clog2(MF_FRAMES);
  localparam int SMF_W      = $clog2(SMF_FRAMES);
  localparam int CRC_W      = 4;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [FN_W-1:0]  fnum_t;

  // low terms of x^4 + x + 1
  localparam crc_t CRC_TAPS = 4'b0011;
  // alignment bits for odd frames 1,3,5,7,9,11 (MSB first)
  localparam logic [5:0] ALIGN_PAT = 6'b001011;

  function automatic crc_t crc_step(crc_t r, logic d);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction
endpackage

// File: rtl/e1mf_frame_track.sv
module e1mf_frame_track #(
  parameter int FRAMES = 16,
  parameter int FW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ts0_mark,
  output logic [FW-1:0] fnum,
  output logic          sof,
  output logic          armed
);
  logic ts0_q;
  logic eof;

  assign sof = ts0_mark & ~ts0_q;
  assign eof = ts0_q & ~ts0_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts0_q <= 1'b0;
      fnum  <= '0;
      armed <= 1'b0;
    end else begin
      ts0_q <= ts0_mark;
      if (eof) fnum <= (fnum == FW'(FRAMES - 1)) ? '0 : fnum + 1'b1;
      if (sof) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/e1mf_crc_accum.sv
module e1mf_crc_accum
  import e1mf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic sof,
  input  logic smf_start,
  input  logic cpos,
  input  logic armed,
  output crc_t crc_live,
  output crc_t crc_hold
);
  logic bit_m;
  assign bit_m = cpos ? 1'b0 : data_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_live <= '0;
      crc_hold <= '0;
    end else if (sof && smf_start) begin
      crc_hold <= crc_live;
      crc_live <= crc_step('0, bit_m);
    end else if (sof || armed) begin
      crc_live <= crc_step(crc_live, bit_m);
    end
  end
endmodule

// File: rtl/e1mf_spare_sel.sv
module e1mf_spare_sel
  import e1mf_pkg::*;
(
  input  fnum_t fnum,
  input  crc_t  crc_live,
  input  crc_t  crc_hold,
  input  logic  crc_en,
  input  logic  sync_mark,
  input  logic  usr_sync,
  input  logic  usr_nonsync,
  output logic  spare_bit
);
  logic [FN_W-2:0] pair;
  crc_t            word;
  logic            crc_bit;
  logic            odd_bit;

  assign pair = fnum[FN_W-1:1];
  // first sync frame of a half takes the word that has just completed
  assign word = (fnum[SMF_W-1:0] == '0) ? crc_live : crc_hold;

  always_comb begin
    case (fnum[SMF_W-1:1])
      2'd0:    crc_bit = word[3];
      2'd1:    crc_bit = word[2];
      2'd2:    crc_bit = word[1];
      default: crc_bit = word[0];
    endcase
  end

  always_comb begin
    case (pair)
      3'd6:    odd_bit = usr_sync;
      3'd7:    odd_bit = usr_nonsync;
      default: odd_bit = ALIGN_PAT[3'd5 - pair];
    endcase
  end

  always_comb begin
    if (!crc_en)       spare_bit = sync_mark ? usr_sync : usr_nonsync;
    else if (fnum[0])  spare_bit = odd_bit;
    else               spare_bit = crc_bit;
  end
endmodule

// File: rtl/e1mf_spare_gen.sv
module e1mf_spare_gen
  import e1mf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ts0_mark,
  input  logic sync_mark,
  input  logic pcm_in,
  input  logic usr_sync,
  input  logic usr_nonsync,
  input  logic crc_en,
  output logic spare_bit
);
  fnum_t fnum;
  logic  sof;
  logic  armed;
  crc_t  crc_live;
  crc_t  crc_hold;

  e1mf_frame_track #(.FRAMES(MF_FRAMES), .FW(FN_W)) u_track (
    .clk(clk), .rst(rst), .ts0_mark(ts0_mark),
    .fnum(fnum), .sof(sof), .armed(armed)
  );

  e1mf_crc_accum u_crc (
    .clk(clk), .rst(rst), .data_in(pcm_in), .sof(sof),
    .smf_start(fnum[SMF_W-1:0] == '0), .cpos(sof & ~fnum[0]),
    .armed(armed), .crc_live(crc_live), .crc_hold(crc_hold)
  );

  e1mf_spare_sel u_sel (
    .fnum(fnum), .crc_live(crc_live), .crc_hold(crc_hold),
    .crc_en(crc_en), .sync_mark(sync_mark), .usr_sync(usr_sync),
    .usr_nonsync(usr_nonsync), .spare_bit(spare_bit)
  );
endmodule

// File: rtl/e1mf_spare_gen_chk.sv
module e1mf_spare_gen_chk
  import e1mf_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  ts0_mark,
  input logic  crc_en,
  input logic  spare_bit,
  input fnum_t fnum,
  input crc_t  crc_hold,
  input logic  armed
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEARS: assert (fnum == '0 && !armed && crc_hold == '0); // R8
    end
  end

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R8

  AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    ($fell(ts0_mark) && !$past(rst)) |=> (fnum == FN_W'($past(fnum) + 1'b1))); // R2

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$fell(ts0_mark) && !$past(rst)) |=> $stable(fnum)); // R2

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(ts0_mark && !$past(ts0_mark) && fnum[SMF_W-1:0] == '0))
    |=> $stable(crc_hold)); // R6

  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (crc_en && (fnum == 4'd1 || fnum == 4'd3 || fnum == 4'd7)) |-> !spare_bit); // R4

  AST_ALIGN_ONE: assert property (@(posedge clk) disable iff (rst)
    (crc_en && (fnum == 4'd5 || fnum == 4'd9 || fnum == 4'd11)) |-> spare_bit); // R4
endmodule

bind e1mf_spare_gen e1mf_spare_gen_chk u_chk (
  .clk(clk), .rst(rst), .ts0_mark(ts0_mark), .crc_en(crc_en),
  .spare_bit(spare_bit), .fnum(fnum), .crc_hold(crc_hold), .armed(armed)
);

// File: tb/e1mf_spare_gen_bench.sv
`timescale 1ns/1ps
module e1mf_spare_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts0_mark = 1'b0;
  logic sync_mark = 1'b1;
  logic pcm_in = 1'b0;
  logic usr_sync = 1'b0;
  logic usr_nonsync = 1'b0;
  logic crc_en = 1'b1;
  logic spare_bit;

  always #2 clk = ~clk;

  e1mf_spare_gen u_e1mf_spare_gen (
    .clk(clk), .rst(rst), .ts0_mark(ts0_mark), .sync_mark(sync_mark),
    .pcm_in(pcm_in), .usr_sync(usr_sync), .usr_nonsync(usr_nonsync),
    .crc_en(crc_en), .spare_bit(spare_bit)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  int         g;
  logic [3:0] prev_crc;
  bit         smf[$];
  string      extra;

  function automatic logic [3:0] ref_crc(input bit q[$]);
    logic [4:0] w;
    w = '0;
    foreach (q[i]) begin
      w = {w[3:0], q[i]};
      if (w[4]) w = w ^ 5'b10011;
    end
    repeat (4) begin
      w = {w[3:0], 1'b0};
      if (w[4]) w = w ^ 5'b10011;
    end
    return w[3:0];
  endfunction

  task automatic push_expect();
    int    m;
    bit    e;
    string t;
    m = g % 16;
    if (m % 8 == 0) begin
      prev_crc = (smf.size() == 2048) ? ref_crc(smf) : 4'b0000;
      smf.delete();
    end
    if (!crc_en) begin
      e = (m % 2 == 0) ? usr_sync : usr_nonsync;
      t = "R1";
    end else if (m % 2 == 0) begin
      e = prev_crc[3 - (m % 8) / 2];
      t = "R3 R6";
    end else begin
      case (m)
        5, 9, 11: begin e = 1'b1; t = "R4"; end
        13:       begin e = usr_sync; t = "R5"; end
        15:       begin e = usr_nonsync; t = "R5"; end
        default:  begin e = 1'b0; t = "R4"; end
      endcase
    end
    exp_q.push_back(e);
    tag_q.push_back({t, " R2 R7", extra});
  endtask

  task automatic drive_frame(input int mode, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      if (b == 0) push_expect();
      ts0_mark = (b < 8);
      pcm_in = (mode == 1) ? 1'b1 : 1'($urandom);
      if (b == 9) sync_mark = ((g + 1) % 2 == 0);
      if (b == 100) begin
        usr_sync = 1'($urandom);
        usr_nonsync = 1'($urandom);
      end
      smf.push_back((b == 0 && g % 2 == 0) ? 1'b0 : pcm_in);
    end
    if (nbits == 256) g++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ts0_mark = 1'b0;
    sync_mark = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    g = 0;
    prev_crc = 4'b0000;
    smf.delete();
  endtask

  // monitor: compare at the cycle before the first timeslot-zero edge
  initial begin
    bit prev_ts0;
    prev_ts0 = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (ts0_mark && !prev_ts0 && !rst) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 frame start without expectation: actual %0b expected none", spare_bit);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (spare_bit !== e) begin
            n_fail++;
            $display("FAIL %s frame %0d: actual %0b expected %0b", t, g % 16, spare_bit, e);
          end
        end
      end
      prev_ts0 = ts0_mark;
    end
  end

  initial begin
    g = 0;
    prev_crc = 4'b0000;
    extra = " R8";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8 first half after reset sends zero word, then CRC mode on random data
    for (int f = 0; f < 48; f++) begin
      if (f == 8) extra = "";
      drive_frame(0, 256);
    end
    // R1 pass-through with CRC mode off
    crc_en = 1'b0;
    for (int f = 0; f < 16; f++) drive_frame(0, 256);
    // R9 re-enable: words must reflect data sent while disabled
    crc_en = 1'b1;
    extra = " R9";
    for (int f = 0; f < 8; f++) drive_frame(0, 256);
    extra = "";
    // all-ones payload
    for (int f = 0; f < 16; f++) drive_frame(1, 256);
    // R8 reset in mid-frame: later bits must be excluded
    drive_frame(0, 100);
    do_reset();
    extra = " R8";
    for (int f = 0; f < 24; f++) begin
      if (f == 8) extra = "";
      drive_frame(0, 256);
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule